// File: doc/BRIEF.md
# Three-Wire Serial Memory Shifter

This block runs the data side of a three-wire serial memory link. A single command write selects the direction (shift out or sample in), a bit count and a release flag. For an outbound command the block loads a transmit byte and presents it on a half-duplex data pin, most significant bit first. For an inbound command it floats the pin and collects the incoming bits into a receive register. It also generates the serial clock, holds a busy flag while a transfer is in progress, and pulses a completion interrupt at the end.

The serial clock is derived from the system clock by a divider whose half-period is set on an input. The clock idles low, and its high and low phases are the same length. A command with a zero count makes no clock pulses and raises no interrupt. Its only effect is to set the pin drive from the release flag, so that software can take back a pin that a memory device left floating after a read. The chip-select line is driven elsewhere and is not part of this block.

Top module: `sw3_shifter`

## Requirements
- R1: When `cmd_we` is high on a clock edge and `busy` is low, a command with an effective count n>0 is accepted and `busy` reads 1 in the next cycle. Field meanings: `cmd_rd`=1 is inbound (read) and 0 is outbound (write); `cmd_cnt` is the bit count; `cmd_rel`=1 asks for the pin to be released after a write.
- R2: The effective count n is `cmd_cnt`, capped at 8. The block emits exactly n `sclk` pulses. With H=`clk_div`+1, each high phase and each low phase lasts H system cycles, and `busy` stays high for 2·H·n cycles. `sclk` is low whenever `busy` is low.
- R3: On a write, the bits tx_data[7], tx_data[6] and onward appear on `sd_out` one per `sclk` pulse. `sd_out` changes only while `sclk` is low.
- R4: During a write, `sd_oe` is 1. After the last bit, `sd_oe` becomes 0 if `cmd_rel`=1 and stays 1 if `cmd_rel`=0.
- R5: During a read, `sd_oe` is 0 for the whole transfer. `sd_in` is sampled on each rising `sclk` edge, and the k-th sample (k=0 first) goes into rx_data[7-k]. Bits that are not sampled read 0. `rx_data` is updated when the transfer ends, and `sd_oe` stays 0 afterwards.
- R6: When a transfer with n>0 ends, `done_irq` is high for exactly one cycle. This is the cycle in which `busy` first reads 0, and it is never high while `busy` is high.
- R7: A command with n=0 makes no `sclk` pulse, does not raise `busy` and does not raise `done_irq`. From the next cycle on, `sd_oe` equals NOT `cmd_rel`.
- R8: A command write that arrives while `busy` is high is ignored. The running transfer keeps its length, its data and its final pin state.
- R9: `rx_data` keeps its value through write commands and zero-count commands. It changes only at the end of a read.
- R10: After reset, `sclk`, `busy`, `done_irq`, `sd_oe`, `sd_out` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cmd_we | input | 1 | Command write strobe |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_cnt | input | CNT_W | Requested bit count |
| cmd_rel | input | 1 | Release the pin after a write; pin state for a zero-count command |
| tx_data | input | DATA_W | Byte to shift out |
| rx_data | output | DATA_W | Byte collected by the last read |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| sd_out | output | 1 | Data pin output value |
| sd_oe | output | 1 | Data pin drive enable |
| sd_in | input | 1 | Data pin input value |

## Verification
The command table mixes full 8-bit writes, short writes that end with the pin released, reads of full and partial length across several divider settings, zero-count commands with either release value, and an oversize count. Short and oversize counts separate a correct bit counter from one that is off by one or does not cap the count. Partial reads show whether the incoming bits are left-aligned with zero fill. Directed cases inject a second command in the middle of a transfer, reclaim the pin after a read, and check that the receive register does not change across write commands.

// File: rtl/sw3_pkg.sv
// Shared types for the three-wire serial shifter.
package sw3_pkg;
    // Serial clock phase of the bit-timing generator.
    typedef enum logic [1:0] {
        SPH_IDLE = 2'd0,
        SPH_LOW  = 2'd1,
        SPH_HIGH = 2'd2
    } sph_e;
endpackage

// File: rtl/sw3_clkgen.sv
// Serial clock generator. When started, it produces low and high phases of
// (div+1) system cycles each. It flags the edge at which sclk rises or falls,
// and goes back to idle (sclk low) on the fall that the controller marks as last.
// Assumes div is held stable while a transfer runs.
module sw3_clkgen
    import sw3_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);
    sph_e             st;
    logic [DIV_W-1:0] ph;
    logic             at_lim;

    // Phase end detection: a phase lasts div+1 cycles.
    always_comb begin
        at_lim   = (ph == div);
        rise_now = (st == SPH_LOW)  && at_lim;
        fall_now = (st == SPH_HIGH) && at_lim;
    end

    // Phase sequencing and serial clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= SPH_IDLE;
            ph   <= '0;
            sclk <= 1'b0;
        end else if (start) begin
            st   <= SPH_LOW;
            ph   <= '0;
            sclk <= 1'b0;
        end else if (rise_now) begin
            st   <= SPH_HIGH;
            ph   <= '0;
            sclk <= 1'b1;
        end else if (fall_now) begin
            st   <= last ? SPH_IDLE : SPH_LOW;
            ph   <= '0;
            sclk <= 1'b0;
        end else if (st != SPH_IDLE) begin
            ph   <= ph + 1'b1;
        end
    end

    // R2: sclk is never high while the generator is idle.
    p_high_only_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SPH_IDLE) |-> !sclk);
endmodule

// File: rtl/sw3_ctrl.sv
// Command controller. It accepts a command only while idle, caps the count at
// DATA_W, counts the remaining bits down on each falling serial clock edge,
// and drives busy and a one-cycle completion pulse. A zero count is reported
// as a pin-state-only command. Assumes cmd_* fields are valid with cmd_we.
module sw3_ctrl #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic             cmd_rd,
    input  logic [CNT_W-1:0] cmd_cnt,
    input  logic             cmd_rel,
    input  logic             fall_now,
    output logic             start,
    output logic             zero_cmd,
    output logic             last,
    output logic             busy,
    output logic             done_irq,
    output logic             rd_q,
    output logic             rel_q
);
    localparam int BC_W = $clog2(DATA_W + 1);

    logic [BC_W-1:0] eff_n;
    logic [BC_W-1:0] bits_left;
    logic            accept;

    // Effective count: the requested count capped at DATA_W.
    always_comb begin
        if (int'(cmd_cnt) > DATA_W) eff_n = BC_W'(DATA_W);
        else                        eff_n = BC_W'(cmd_cnt);
        accept   = cmd_we && !busy;
        start    = accept && (eff_n != '0);
        zero_cmd = accept && (eff_n == '0);
        last     = (bits_left == BC_W'(1));
    end

    // Busy flag, remaining-bit counter and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done_irq  <= 1'b0;
            bits_left <= '0;
        end else begin
            done_irq <= 1'b0;
            if (start) begin
                busy      <= 1'b1;
                bits_left <= eff_n;
            end else if (fall_now) begin
                bits_left <= bits_left - 1'b1;
                if (last) begin
                    busy     <= 1'b0;
                    done_irq <= 1'b1;
                end
            end
        end
    end

    // Direction and release flag held for the running transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= 1'b0;
            rel_q <= 1'b0;
        end else if (start) begin
            rd_q  <= cmd_rd;
            rel_q <= cmd_rel;
        end
    end

    // R6: the completion pulse comes exactly when busy drops.
    p_irq_on_busy_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $fell(busy));

    // R8: while busy, only a falling serial edge moves the bit counter.
    p_ignore_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fall_now) |=> (bits_left == $past(bits_left)));
endmodule

// File: rtl/sw3_datapath.sv
// Data path. Holds the transmit shift register (MSB first, updated on falling
// serial edges), the receive collector (sampled on rising serial edges, filled
// from the MSB down), the receive register and the pin drive enable.
// Assumes start, rise_now, fall_now and last come from sw3_ctrl/sw3_clkgen.
module sw3_datapath #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              zero_cmd,
    input  logic              cmd_rd,
    input  logic              cmd_rel,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rise_now,
    input  logic              fall_now,
    input  logic              last,
    input  logic              rd_q,
    input  logic              rel_q,
    input  logic              busy,
    input  logic              sclk,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [DATA_W-1:0] rx_data
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int MSB   = DATA_W - 1;

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [IDX_W-1:0]  pos;

    // Transmit shifter and output bit, which changes only at start or on a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            sd_out <= 1'b0;
        end else if (start) begin
            tx_sh <= tx_data;
            if (!cmd_rd) sd_out <= tx_data[MSB];
        end else if (fall_now && !last && !rd_q) begin
            tx_sh  <= tx_sh << 1;
            sd_out <= tx_sh[MSB-1];
        end
    end

    // Receive collector: rising-edge samples placed from the MSB downward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh <= '0;
            pos   <= IDX_W'(MSB);
        end else if (start) begin
            rx_sh <= '0;
            pos   <= IDX_W'(MSB);
        end else if (rise_now && rd_q) begin
            rx_sh[pos] <= sd_in;
            pos        <= pos - 1'b1;
        end
    end

    // Receive register: loaded only when a read finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_data <= '0;
        else if (fall_now && last && rd_q)   rx_data <= rx_sh;
    end

    // Pin drive enable: set per command, settled at the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sd_oe <= 1'b0;
        else if (start)             sd_oe <= !cmd_rd;
        else if (zero_cmd)          sd_oe <= !cmd_rel;
        else if (fall_now && last)  sd_oe <= !rd_q && !rel_q;
    end

    // R3: the output bit holds while the serial clock stays high.
    p_tx_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sd_out));

    // R4: the pin is driven for the whole of a write.
    p_write_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_q) |-> sd_oe);

    // R5: the pin floats for the whole of a read.
    p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_q) |-> !sd_oe);
endmodule

// File: rtl/sw3_shifter.sv
// Top level of the three-wire serial shifter. Ties the command controller,
// the serial clock generator and the data path together. The pin is split into
// out/enable/in; the pad ring combines them. Chip select is handled elsewhere.
module sw3_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              cmd_we,
    input  logic              cmd_rd,
    input  logic [CNT_W-1:0]  cmd_cnt,
    input  logic              cmd_rel,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done_irq,
    output logic              sclk,
    output logic              sd_out,
    output logic              sd_oe,
    input  logic              sd_in
);
    logic start, zero_cmd, last, rd_q, rel_q, rise_now, fall_now;

    sw3_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_rd(cmd_rd),
        .cmd_cnt(cmd_cnt), .cmd_rel(cmd_rel), .fall_now(fall_now),
        .start(start), .zero_cmd(zero_cmd), .last(last), .busy(busy),
        .done_irq(done_irq), .rd_q(rd_q), .rel_q(rel_q)
    );

    sw3_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .start(start), .last(last), .div(clk_div),
        .sclk(sclk), .rise_now(rise_now), .fall_now(fall_now)
    );

    sw3_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .start(start), .zero_cmd(zero_cmd),
        .cmd_rd(cmd_rd), .cmd_rel(cmd_rel), .tx_data(tx_data),
        .rise_now(rise_now), .fall_now(fall_now), .last(last), .rd_q(rd_q),
        .rel_q(rel_q), .busy(busy), .sclk(sclk), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .rx_data(rx_data)
    );

    // R2: the serial clock idles low outside a transfer.
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R9: the receive register moves only together with a completion pulse.
    p_rx_only_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> done_irq);
endmodule

// File: tb/sw3_shifter_tb_top.sv
// Self-checking bench for sw3_shifter: a command table followed by directed cases.
module sw3_shifter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] clk_div = 8'd1;
    logic       cmd_we = 1'b0, cmd_rd = 1'b0, cmd_rel = 1'b0;
    logic [3:0] cmd_cnt = '0;
    logic [7:0] tx_data = '0;
    logic [7:0] rx_data;
    logic       busy, done_irq, sclk, sd_out, sd_oe;
    logic       sd_in = 1'b0;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_rx = 8'h00;

    always #5 clk = ~clk;

    sw3_shifter dut_i (
        .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .cmd_we(cmd_we),
        .cmd_rd(cmd_rd), .cmd_cnt(cmd_cnt), .cmd_rel(cmd_rel),
        .tx_data(tx_data), .rx_data(rx_data), .busy(busy),
        .done_irq(done_irq), .sclk(sclk), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in)
    );

    // Vector layout: {rd, rel, div[1:0], cnt[3:0], tx[7:0], pat[7:0]}
    localparam int NV = 9;
    localparam logic [23:0] VEC [NV] = '{
        24'h18A500,  // write 8 bits, hold pin, H=2
        24'h43C000,  // write 3 bits, release, H=1
        24'h98003C,  // read 8 bits, H=2
        24'hA500B7,  // read 5 bits, H=3
        24'h50FF00,  // zero count, release
        24'h10FF00,  // zero count, reclaim
        24'h1C8100,  // oversize count 12 -> 8
        24'hB10080,  // read 1 bit, H=4
        24'h785A00   // write 8 bits, release, H=4
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input bit rd, input int cnt, input bit rel, input int div,
                           input logic [7:0] tx, input logic [7:0] pat, input bit inj);
        int n = (cnt > 8) ? 8 : cnt;
        int h = div + 1;
        int busy_cyc = 0, rises = 0, irq_early = 0, width_bad = 0;
        int oe_bad = 0, hold_bad = 0, hi_len = 0, lo_len = 0;
        logic [7:0] wbits = '0;
        logic prev_sclk = 1'b0, prev_out = 1'b0;
        @(negedge clk);
        clk_div = 8'(div); cmd_rd = rd; cmd_cnt = 4'(cnt); cmd_rel = rel;
        tx_data = tx; sd_in = pat[7]; cmd_we = 1'b1;
        @(negedge clk);
        cmd_we = 1'b0;
        chk(busy == (n > 0), "R1 busy after accept", int'(busy), int'(n > 0));
        while (busy && busy_cyc < 2000) begin
            busy_cyc++;
            if (done_irq) irq_early++;
            if (sclk) begin
                if (!prev_sclk) begin
                    rises++;
                    wbits = {wbits[6:0], sd_out};
                    if (rises < 8) sd_in = pat[7 - rises];
                    if (lo_len != h) width_bad++;
                    lo_len = 0;
                end else if (sd_out != prev_out) begin
                    hold_bad++;
                end
                hi_len++;
            end else begin
                if (prev_sclk) begin
                    if (hi_len != h) width_bad++;
                    hi_len = 0;
                end
                lo_len++;
            end
            if (sd_oe != !rd) oe_bad++;
            if (inj && busy_cyc == 3) begin
                cmd_we = 1'b1; cmd_rd = ~rd; cmd_cnt = 4'd8;
                cmd_rel = ~rel; tx_data = ~tx;
            end
            if (inj && busy_cyc == 4) cmd_we = 1'b0;
            prev_sclk = sclk; prev_out = sd_out;
            @(negedge clk);
        end
        cmd_we = 1'b0;
        if (n > 0 && hi_len != h) width_bad++;
        // R2: cycle count, pulse count, phase widths
        chk(busy_cyc == 2 * h * n, "R2/R8 busy length", busy_cyc, 2 * h * n);
        chk(rises == n, "R2/R7 sclk pulse count", rises, n);
        chk(width_bad == 0, "R2 phase widths", width_bad, 0);
        chk(!sclk, "R2 sclk idle low", int'(sclk), 0);
        // R6 / R7: completion pulse
        chk(done_irq == (n > 0) && irq_early == 0, "R6/R7 done_irq",
            int'(done_irq), int'(n > 0));
        if (n > 0) begin
            @(negedge clk);
            chk(!done_irq, "R6 one-cycle pulse", int'(done_irq), 0);
        end
        // R4 / R5 / R7: final pin drive
        if (n == 0) chk(sd_oe == !rel, "R7 pin state", int'(sd_oe), int'(!rel));
        else if (rd) chk(!sd_oe && oe_bad == 0, "R5 pin floats", int'(sd_oe) + oe_bad, 0);
        else chk(sd_oe == !rel && oe_bad == 0, "R4 pin drive", int'(sd_oe), int'(!rel));
        if (!rd && n > 0) begin
            int expb = int'(tx) >> (8 - n);
            int actb = int'(wbits) & ((1 << n) - 1);
            chk(actb == expb, "R3 bits out MSB first", actb, expb);
            chk(hold_bad == 0, "R3 data stable while sclk high", hold_bad, 0);
        end
        if (rd && n > 0) exp_rx = pat & (8'hFF << (8 - n));
        chk(rx_data == exp_rx, rd ? "R5 rx_data" : "R9 rx_data held",
            int'(rx_data), int'(exp_rx));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({sclk, busy, done_irq, sd_oe, sd_out} == 5'b0, "R10 reset outputs",
            int'({sclk, busy, done_irq, sd_oe, sd_out}), 0);
        chk(rx_data == 8'h00, "R10 reset rx_data", int'(rx_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            logic [23:0] v = VEC[i];
            run_cmd(v[23], int'(v[19:16]), v[22], int'(v[21:20]), v[15:8], v[7:0], 1'b0);
        end
        // R8: a command injected mid-transfer is ignored
        run_cmd(1'b0, 4, 1'b0, 1, 8'h96, 8'h00, 1'b1);
        run_cmd(1'b0, 8, 1'b1, 2, 8'h3C, 8'h00, 1'b1);
        // R7: reclaim the pin after a read with a zero-count command
        run_cmd(1'b1, 8, 1'b0, 0, 8'h00, 8'h6E, 1'b0);
        run_cmd(1'b0, 0, 1'b0, 0, 8'h00, 8'h00, 1'b0);
        // R9: a zero-count command and a write leave rx_data alone
        run_cmd(1'b0, 0, 1'b1, 0, 8'h00, 8'h00, 1'b0);
        run_cmd(1'b0, 2, 1'b0, 0, 8'hFF, 8'h00, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule